// File: doc/BRIEF.md
# Effective Address and Next-PC Unit

This block sits in the decode stage of a 12-bit word machine whose memory is split into eight 4096-word fields. For each instruction word it forms the operand address and decides whether a pointer fetch must come first. It decides whether that pointer is bumped on the way and produces the write-back words that some instructions need. It also works out the program counter of the next instruction. The inputs are the data field, the instruction field, the current 15-bit program counter, the instruction word, the pointer word fetched for indirect access and the operand word. All results are registered, so they appear one clock after an accepted request.

An interrupt request replaces the instruction with a subroutine call to location 0 of field 0. The PC is saved without being incremented. An interrupt that arrives while either field is nonzero is flagged on a fault output. Memory timing and the sequencing of the pointer fetch belong to the surrounding pipeline.

Top module: `ea_pc_unit`

## Requirements
- R1: When no skip or jump applies, the next PC keeps bits 14:12 of the current PC and takes the low 12 bits plus one, modulo 4096.
- R2: For every instruction word, the initial address is the data field in bits 14:12, then bits 11:7 taken from the PC when instruction bit 7 (octal 0200) is 1 or zeros when it is 0, then instruction bits 6:0.
- R3: The opcode is instruction bits 11:9 (0 AND, 1 TAD, 2 ISZ, 3 DCA, 4 JMS, 5 JMP, 6 IOT, 7 OPR). For opcodes 0 to 5, instruction bit 8 (octal 0400) raises the indirect request. Without it, the final address equals the initial address.
- R4: For an indirect access, the final address is the data field above the pointer word, or above the pointer word plus one when an auto-increment is requested.
- R5: An indirect access with opcode 0 to 3 whose initial address has low 12 bits in octal 0010 to 0017 raises the auto-increment request. The pointer write-back word is then the pointer plus one, modulo 4096. Jumps (opcodes 4 and 5) never raise it.
- R6: JMP sets the next PC to the instruction field above the low 12 bits of the final address.
- R7: JMS sets the next PC to the instruction field above the final address's low 12 bits plus one, modulo 4096. It raises the operand write-back with the value PC+1 (low 12 bits).
- R8: ISZ raises the operand write-back with the operand plus one, modulo 4096. When that value is zero it sets the skip output and advances the next PC by two within the field.
- R9: An interrupt replaces the instruction by a direct JMS to address 0. The write-back word is the unincremented PC, and the next PC is the instruction field above 0001.
- R10: An interrupt with a nonzero data or instruction field sets the fault output. Without an interrupt the fault output stays 0.
- R11: IOT and OPR words raise no indirect, auto-increment, write-back or skip, and take the sequential next PC.
- R12: Outputs are registered: results of a request accepted at one rising edge are held until the next accepted request. The valid output is high only in the cycle after acceptance, and all outputs are 0 under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted at this rising edge |
| df_in | input | 3 | Data field |
| if_in | input | 3 | Instruction field |
| pc_in | input | 15 | Current program counter |
| instr_in | input | 12 | Instruction word |
| irq_in | input | 1 | Interrupt entry request |
| ptr_in | input | 12 | Pointer word fetched for indirect access |
| opnd_in | input | 12 | Operand word (ISZ) |
| out_valid | output | 1 | Results updated this cycle |
| ea_init_o | output | 15 | Initial operand address |
| ea_final_o | output | 15 | Final operand address |
| ind_req_o | output | 1 | Pointer fetch needed |
| ai_req_o | output | 1 | Pointer auto-increment write-back needed |
| ptr_wb_o | output | 12 | Incremented pointer word |
| next_pc_o | output | 15 | Next program counter |
| op_wb_en_o | output | 1 | Operand write-back at the final address |
| op_wb_o | output | 12 | Operand write-back word |
| skip_o | output | 1 | ISZ result zero, next instruction skipped |
| irq_fault_o | output | 1 | Interrupt arrived with a nonzero field |

## Verification
The assertions take the pointer and operand words as already fetched by the time the request is accepted, and they take in_valid to be a clean level after reset. The interrupt-entry property covers only requests whose fields are both zero. The fault property covers the remaining interrupt cases. The bench changes all inputs on the falling edge, holds them for exactly one accepted edge and drops in_valid between requests. It uses nonzero fields with an interrupt only in the scenario aimed at the fault output.

// File: rtl/eap_pkg.sv
package eap_pkg;

   typedef enum logic [2:0] {
      OP_AND = 3'd0,
      OP_TAD = 3'd1,
      OP_ISZ = 3'd2,
      OP_DCA = 3'd3,
      OP_JMS = 3'd4,
      OP_JMP = 3'd5,
      OP_IOT = 3'd6,
      OP_OPR = 3'd7
   } opcode_e;

   localparam int OPC_W = 3;

   // memory-reference opcodes are 0..5
   function automatic logic is_memref(opcode_e op);
      return (op != OP_IOT) && (op != OP_OPR);
   endfunction

   // data-only memory references (no change of flow)
   function automatic logic is_data_ref(opcode_e op);
      return (op == OP_AND) || (op == OP_TAD) || (op == OP_ISZ) || (op == OP_DCA);
   endfunction

endpackage

// File: rtl/eap_addr_gen.sv
module eap_addr_gen #(
   parameter  int WORD_W     = 12,
   parameter  int FIELD_W    = 3,
   parameter  bit AUTOINC_EN = 1'b1,
   parameter  int AI_BASE    = 8,
   parameter  int AI_COUNT   = 8,
   localparam int ADDR_W     = WORD_W + FIELD_W
) (
   input  logic [FIELD_W-1:0] df,
   input  logic [WORD_W-1:0]  pc_low,
   input  logic [WORD_W-1:0]  instr,
   input  logic [WORD_W-1:0]  ptr_word,
   input  logic               memref,
   input  logic               data_ref,
   output logic [ADDR_W-1:0]  ea_init,
   output logic [ADDR_W-1:0]  ea_final,
   output logic               need_ind,
   output logic               need_ai,
   output logic [WORD_W-1:0]  ptr_inc
);

   localparam int PAGE_OFS_W = WORD_W - 5;
   localparam int PAGE_W     = WORD_W - PAGE_OFS_W;
   localparam int AI_SH      = $clog2(AI_COUNT);
   localparam int TAG_W      = WORD_W - AI_SH;
   localparam logic [TAG_W-1:0] AI_TAG = TAG_W'(AI_BASE >> AI_SH);

   logic              page_sel;
   logic              ind_bit;
   logic [PAGE_W-1:0] page_bits;
   logic [WORD_W-1:0] init_low;
   logic [WORD_W-1:0] final_low;

   assign page_sel  = instr[PAGE_OFS_W];
   assign ind_bit   = instr[PAGE_OFS_W+1];
   assign page_bits = page_sel ? pc_low[WORD_W-1:PAGE_OFS_W] : '0;
   assign init_low  = {page_bits, instr[PAGE_OFS_W-1:0]};
   assign need_ind  = memref & ind_bit;
   assign ptr_inc   = ptr_word + 1'b1;

   generate
      if (AUTOINC_EN) begin : g_ai
         logic in_win;
         assign in_win  = (init_low[WORD_W-1:AI_SH] == AI_TAG);
         assign need_ai = need_ind & data_ref & in_win;
      end else begin : g_no_ai
         logic unused_ai;
         assign unused_ai = data_ref;
         assign need_ai   = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!need_ind)
         final_low = init_low;
      else if (need_ai)
         final_low = ptr_inc;
      else
         final_low = ptr_word;
   end

   assign ea_init  = {df, init_low};
   assign ea_final = {df, final_low};

endmodule

// File: rtl/eap_pc_gen.sv
module eap_pc_gen #(
   parameter  int WORD_W  = 12,
   parameter  int FIELD_W = 3,
   localparam int ADDR_W  = WORD_W + FIELD_W
) (
   input  eap_pkg::opcode_e   op,
   input  logic [ADDR_W-1:0]  pc,
   input  logic [FIELD_W-1:0] ifld,
   input  logic               hold,
   input  logic [WORD_W-1:0]  final_low,
   input  logic [WORD_W-1:0]  opnd,
   output logic [ADDR_W-1:0]  next_pc,
   output logic [WORD_W-1:0]  ret_word
);
   import eap_pkg::*;

   logic [FIELD_W-1:0] cur_fld;
   logic [WORD_W-1:0]  cur_low;
   logic [WORD_W-1:0]  seq_low;
   logic [WORD_W-1:0]  skip_low;
   logic [WORD_W-1:0]  sub_low;
   logic               isz_zero;

   assign cur_fld  = pc[ADDR_W-1:WORD_W];
   assign cur_low  = pc[WORD_W-1:0];
   assign seq_low  = hold ? cur_low : cur_low + 1'b1;
   assign skip_low = seq_low + 1'b1;
   assign sub_low  = final_low + 1'b1;
   // operand of all ones wraps to zero after increment
   assign isz_zero = &opnd;
   assign ret_word = seq_low;

   always_comb begin
      case (op)
         OP_JMP:  next_pc = {ifld, final_low};
         OP_JMS:  next_pc = {ifld, sub_low};
         OP_ISZ:  next_pc = {cur_fld, (isz_zero ? skip_low : seq_low)};
         default: next_pc = {cur_fld, seq_low};
      endcase
   end

endmodule

// File: rtl/eap_wb_gen.sv
module eap_wb_gen #(
   parameter int WORD_W = 12
) (
   input  eap_pkg::opcode_e  op,
   input  logic [WORD_W-1:0] opnd,
   input  logic [WORD_W-1:0] ret_word,
   output logic              wb_en,
   output logic [WORD_W-1:0] wb_word,
   output logic              skip
);
   import eap_pkg::*;

   logic [WORD_W-1:0] isz_word;

   assign isz_word = opnd + 1'b1;

   always_comb begin
      wb_en   = 1'b0;
      wb_word = '0;
      skip    = 1'b0;
      case (op)
         OP_JMS: begin
            wb_en   = 1'b1;
            wb_word = ret_word;
         end
         OP_ISZ: begin
            wb_en   = 1'b1;
            wb_word = isz_word;
            skip    = (isz_word == '0);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ea_pc_unit.sv
module ea_pc_unit #(
   parameter  int WORD_W     = 12,
   parameter  int FIELD_W    = 3,
   parameter  bit AUTOINC_EN = 1'b1,
   parameter  int AI_BASE    = 8,
   parameter  int AI_COUNT   = 8,
   localparam int ADDR_W     = WORD_W + FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [FIELD_W-1:0] df_in,
   input  logic [FIELD_W-1:0] if_in,
   input  logic [ADDR_W-1:0]  pc_in,
   input  logic [WORD_W-1:0]  instr_in,
   input  logic               irq_in,
   input  logic [WORD_W-1:0]  ptr_in,
   input  logic [WORD_W-1:0]  opnd_in,
   output logic               out_valid,
   output logic [ADDR_W-1:0]  ea_init_o,
   output logic [ADDR_W-1:0]  ea_final_o,
   output logic               ind_req_o,
   output logic               ai_req_o,
   output logic [WORD_W-1:0]  ptr_wb_o,
   output logic [ADDR_W-1:0]  next_pc_o,
   output logic               op_wb_en_o,
   output logic [WORD_W-1:0]  op_wb_o,
   output logic               skip_o,
   output logic               irq_fault_o
);
   import eap_pkg::*;

   localparam int PAGE_OFS_W = WORD_W - 5;
   localparam logic [WORD_W-1:0] IRQ_WORD = {OP_JMS, {(WORD_W-OPC_W){1'b0}}};

   // elaboration-time parameter checks
   if (WORD_W < 8) begin : g_chk_word
      $error("ea_pc_unit: WORD_W must be at least 8");
   end
   if (FIELD_W < 1) begin : g_chk_field
      $error("ea_pc_unit: FIELD_W must be at least 1");
   end
   if ((AI_COUNT < 1) || ((AI_COUNT & (AI_COUNT - 1)) != 0)) begin : g_chk_cnt
      $error("ea_pc_unit: AI_COUNT must be a power of two");
   end
   if ((AI_BASE % AI_COUNT) != 0) begin : g_chk_align
      $error("ea_pc_unit: AI_BASE must be aligned to AI_COUNT");
   end
   if ((AI_BASE + AI_COUNT) > (1 << PAGE_OFS_W)) begin : g_chk_page
      $error("ea_pc_unit: auto-increment window must lie inside page zero");
   end

   logic [WORD_W-1:0]  instr_eff;
   opcode_e            op;
   logic               memref;
   logic               data_ref;
   logic               fault;
   logic [ADDR_W-1:0]  ea_init;
   logic [ADDR_W-1:0]  ea_final;
   logic               need_ind;
   logic               need_ai;
   logic [WORD_W-1:0]  ptr_inc;
   logic [ADDR_W-1:0]  next_pc;
   logic [WORD_W-1:0]  ret_word;
   logic               wb_en;
   logic [WORD_W-1:0]  wb_word;
   logic               skip;

   assign instr_eff = irq_in ? IRQ_WORD : instr_in;
   assign op        = opcode_e'(instr_eff[WORD_W-1 -: OPC_W]);
   assign memref    = is_memref(op);
   assign data_ref  = is_data_ref(op);
   assign fault     = irq_in & ((|df_in) | (|if_in));

   eap_addr_gen #(
      .WORD_W     (WORD_W),
      .FIELD_W    (FIELD_W),
      .AUTOINC_EN (AUTOINC_EN),
      .AI_BASE    (AI_BASE),
      .AI_COUNT   (AI_COUNT)
   ) u_addr (
      .df       (df_in),
      .pc_low   (pc_in[WORD_W-1:0]),
      .instr    (instr_eff),
      .ptr_word (ptr_in),
      .memref   (memref),
      .data_ref (data_ref),
      .ea_init  (ea_init),
      .ea_final (ea_final),
      .need_ind (need_ind),
      .need_ai  (need_ai),
      .ptr_inc  (ptr_inc)
   );

   eap_pc_gen #(
      .WORD_W  (WORD_W),
      .FIELD_W (FIELD_W)
   ) u_pc (
      .op        (op),
      .pc        (pc_in),
      .ifld      (if_in),
      .hold      (irq_in),
      .final_low (ea_final[WORD_W-1:0]),
      .opnd      (opnd_in),
      .next_pc   (next_pc),
      .ret_word  (ret_word)
   );

   eap_wb_gen #(
      .WORD_W (WORD_W)
   ) u_wb (
      .op       (op),
      .opnd     (opnd_in),
      .ret_word (ret_word),
      .wb_en    (wb_en),
      .wb_word  (wb_word),
      .skip     (skip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         ea_init_o   <= '0;
         ea_final_o  <= '0;
         ind_req_o   <= 1'b0;
         ai_req_o    <= 1'b0;
         ptr_wb_o    <= '0;
         next_pc_o   <= '0;
         op_wb_en_o  <= 1'b0;
         op_wb_o     <= '0;
         skip_o      <= 1'b0;
         irq_fault_o <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            ea_init_o   <= ea_init;
            ea_final_o  <= ea_final;
            ind_req_o   <= need_ind;
            ai_req_o    <= need_ai;
            ptr_wb_o    <= ptr_inc;
            next_pc_o   <= next_pc;
            op_wb_en_o  <= wb_en;
            op_wb_o     <= wb_word;
            skip_o      <= skip;
            irq_fault_o <= fault;
         end
      end
   end

endmodule

// File: rtl/ea_pc_unit_chk.sv
module ea_pc_unit_chk #(
   parameter  int WORD_W  = 12,
   parameter  int FIELD_W = 3,
   localparam int ADDR_W  = WORD_W + FIELD_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [FIELD_W-1:0] df_in,
   input logic [FIELD_W-1:0] if_in,
   input logic [ADDR_W-1:0]  pc_in,
   input logic [WORD_W-1:0]  instr_in,
   input logic               irq_in,
   input logic               out_valid,
   input logic [ADDR_W-1:0]  ea_init_o,
   input logic [ADDR_W-1:0]  ea_final_o,
   input logic               ind_req_o,
   input logic               ai_req_o,
   input logic [WORD_W-1:0]  ptr_wb_o,
   input logic [ADDR_W-1:0]  next_pc_o,
   input logic               op_wb_en_o,
   input logic [WORD_W-1:0]  op_wb_o,
   input logic               skip_o,
   input logic               irq_fault_o
);

   localparam int PAGE_OFS_W = WORD_W - 5;
   localparam int ZPAD       = WORD_W - PAGE_OFS_W;

   logic [2:0] opc;
   assign opc = instr_in[WORD_W-1 -: 3];

   AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !irq_in && opc[2:1] == 2'b11)
      |=> next_pc_o == {$past(pc_in[ADDR_W-1:WORD_W]), WORD_W'($past(pc_in[WORD_W-1:0]) + 1'b1)}); // R1

   AST_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !irq_in && !instr_in[PAGE_OFS_W])
      |=> ea_init_o == {$past(df_in), {ZPAD{1'b0}}, $past(instr_in[PAGE_OFS_W-1:0])}); // R2

   AST_IND_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !irq_in && opc[2:1] != 2'b11 && instr_in[PAGE_OFS_W+1]) |=> ind_req_o); // R3

   AST_DIRECT_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !ind_req_o) |-> ea_final_o == ea_init_o); // R3

   AST_AI_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ai_req_o) |-> (ind_req_o && ea_final_o[WORD_W-1:0] == ptr_wb_o)); // R5

   AST_JMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !irq_in && opc == 3'd5)
      |=> (next_pc_o[ADDR_W-1:WORD_W] == $past(if_in)
           && next_pc_o[WORD_W-1:0] == ea_final_o[WORD_W-1:0])); // R6

   AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && skip_o) |-> (op_wb_en_o && op_wb_o == '0)); // R8

   AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && irq_in && df_in == '0 && if_in == '0)
      |=> (next_pc_o == ADDR_W'(1) && op_wb_en_o
           && op_wb_o == $past(pc_in[WORD_W-1:0]) && ea_final_o == '0)); // R9

   AST_IRQ_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && irq_in && (df_in != '0 || if_in != '0)) |=> irq_fault_o); // R10

endmodule

bind ea_pc_unit ea_pc_unit_chk #(
   .WORD_W  (WORD_W),
   .FIELD_W (FIELD_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .df_in       (df_in),
   .if_in       (if_in),
   .pc_in       (pc_in),
   .instr_in    (instr_in),
   .irq_in      (irq_in),
   .out_valid   (out_valid),
   .ea_init_o   (ea_init_o),
   .ea_final_o  (ea_final_o),
   .ind_req_o   (ind_req_o),
   .ai_req_o    (ai_req_o),
   .ptr_wb_o    (ptr_wb_o),
   .next_pc_o   (next_pc_o),
   .op_wb_en_o  (op_wb_en_o),
   .op_wb_o     (op_wb_o),
   .skip_o      (skip_o),
   .irq_fault_o (irq_fault_o)
);

// File: tb/ea_pc_unit_tb.sv
module ea_pc_unit_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  df_in = '0;
   logic [2:0]  if_in = '0;
   logic [14:0] pc_in = '0;
   logic [11:0] instr_in = '0;
   logic        irq_in = 1'b0;
   logic [11:0] ptr_in = '0;
   logic [11:0] opnd_in = '0;
   logic        out_valid;
   logic [14:0] ea_init_o;
   logic [14:0] ea_final_o;
   logic        ind_req_o;
   logic        ai_req_o;
   logic [11:0] ptr_wb_o;
   logic [14:0] next_pc_o;
   logic        op_wb_en_o;
   logic [11:0] op_wb_o;
   logic        skip_o;
   logic        irq_fault_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ea_pc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .df_in(df_in), .if_in(if_in),
      .pc_in(pc_in), .instr_in(instr_in), .irq_in(irq_in), .ptr_in(ptr_in),
      .opnd_in(opnd_in), .out_valid(out_valid), .ea_init_o(ea_init_o),
      .ea_final_o(ea_final_o), .ind_req_o(ind_req_o), .ai_req_o(ai_req_o),
      .ptr_wb_o(ptr_wb_o), .next_pc_o(next_pc_o), .op_wb_en_o(op_wb_en_o),
      .op_wb_o(op_wb_o), .skip_o(skip_o), .irq_fault_o(irq_fault_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
      end
   endtask

   // one accepted request; returns at the next falling edge with results registered
   task automatic apply(input logic [2:0] df, input logic [2:0] ifl, input logic [14:0] pc,
                        input logic [11:0] ins, input logic irq,
                        input logic [11:0] ptr, input logic [11:0] opnd);
      @(negedge clk);
      df_in = df; if_in = ifl; pc_in = pc; instr_in = ins;
      irq_in = irq; ptr_in = ptr; opnd_in = opnd; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; irq_in = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R12 reset valid", 32'(out_valid), 32'd0);
      chk("R12 reset pc", 32'(next_pc_o), 32'd0);
      chk("R12 reset ea", 32'(ea_final_o), 32'd0);
      chk("R12 reset wb", 32'(op_wb_en_o), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_sequential();
      apply(3'o2, 3'o3, 15'o37777, 12'o7200, 1'b0, 12'o0, 12'o0);
      chk("R12 valid", 32'(out_valid), 32'd1);
      chk("R1 wrap keeps field", 32'(next_pc_o), 32'(15'o30000));
      chk("R11 opr no ind", 32'(ind_req_o), 32'd0);
      chk("R11 opr no wb", 32'(op_wb_en_o), 32'd0);
      apply(3'o0, 3'o5, 15'o10100, 12'o6741, 1'b0, 12'o0, 12'o7777);
      chk("R1 iot next pc", 32'(next_pc_o), 32'(15'o10101));
      chk("R11 iot (bit8 set) no ind", 32'(ind_req_o), 32'd0);
      chk("R11 iot no ai", 32'(ai_req_o), 32'd0);
      chk("R11 iot no skip", 32'(skip_o), 32'd0);
   endtask

   task automatic t_page();
      apply(3'o5, 3'o0, 15'o24321, 12'o0045, 1'b0, 12'o0, 12'o0);
      chk("R2 page zero", 32'(ea_init_o), 32'(15'o50045));
      chk("R3 direct final", 32'(ea_final_o), 32'(15'o50045));
      apply(3'o5, 3'o0, 15'o24321, 12'o0245, 1'b0, 12'o0, 12'o0);
      chk("R2 current page", 32'(ea_init_o), 32'(15'o54245));
      chk("R3 direct no ind", 32'(ind_req_o), 32'd0);
   endtask

   task automatic t_indirect();
      apply(3'o4, 3'o1, 15'o10200, 12'o1456, 1'b0, 12'o1234, 12'o0);
      chk("R3 ind req", 32'(ind_req_o), 32'd1);
      chk("R4 init addr", 32'(ea_init_o), 32'(15'o40056));
      chk("R4 final from pointer", 32'(ea_final_o), 32'(15'o41234));
      chk("R5 outside window", 32'(ai_req_o), 32'd0);
   endtask

   task automatic t_autoinc();
      apply(3'o1, 3'o0, 15'o00500, 12'o3412, 1'b0, 12'o7777, 12'o0);
      chk("R5 ai in window", 32'(ai_req_o), 32'd1);
      chk("R5 ptr wb wraps", 32'(ptr_wb_o), 32'(12'o0000));
      chk("R4 final uses bumped ptr", 32'(ea_final_o), 32'(15'o10000));
      apply(3'o0, 3'o0, 15'o00500, 12'o3407, 1'b0, 12'o0100, 12'o0);
      chk("R5 below window", 32'(ai_req_o), 32'd0);
      chk("R4 final plain ptr", 32'(ea_final_o), 32'(15'o00100));
      apply(3'o0, 3'o0, 15'o00500, 12'o0417, 1'b0, 12'o0100, 12'o0);
      chk("R5 top of window", 32'(ai_req_o), 32'd1);
      chk("R5 ptr wb", 32'(ptr_wb_o), 32'(12'o0101));
      apply(3'o0, 3'o0, 15'o00500, 12'o1420, 1'b0, 12'o0100, 12'o0);
      chk("R5 above window", 32'(ai_req_o), 32'd0);
      apply(3'o0, 3'o0, 15'o00050, 12'o2610, 1'b0, 12'o0300, 12'o0005);
      chk("R5 isz page-0 current page", 32'(ai_req_o), 32'd1);
      apply(3'o0, 3'o2, 15'o00050, 12'o5410, 1'b0, 12'o0300, 12'o0);
      chk("R5 jmp never ai", 32'(ai_req_o), 32'd0);
      chk("R6 indirect jmp target", 32'(next_pc_o), 32'(15'o20300));
      apply(3'o0, 3'o2, 15'o00050, 12'o4410, 1'b0, 12'o0300, 12'o0);
      chk("R5 jms never ai", 32'(ai_req_o), 32'd0);
   endtask

   task automatic t_jmp();
      apply(3'o3, 3'o6, 15'o20200, 12'o5123, 1'b0, 12'o0, 12'o0);
      chk("R6 jmp page zero", 32'(next_pc_o), 32'(15'o60123));
      chk("R6 jmp no wb", 32'(op_wb_en_o), 32'd0);
      apply(3'o3, 3'o6, 15'o20200, 12'o5323, 1'b0, 12'o0, 12'o0);
      chk("R6 jmp current page", 32'(next_pc_o), 32'(15'o60323));
   endtask

   task automatic t_jms();
      apply(3'o0, 3'o2, 15'o17777, 12'o4377, 1'b0, 12'o0, 12'o0);
      chk("R7 jms target wraps", 32'(next_pc_o), 32'(15'o20000));
      chk("R7 jms wb en", 32'(op_wb_en_o), 32'd1);
      chk("R7 jms return wraps", 32'(op_wb_o), 32'(12'o0000));
      chk("R7 jms store addr", 32'(ea_final_o), 32'(15'o07777));
      apply(3'o0, 3'o1, 15'o00100, 12'o4020, 1'b0, 12'o0, 12'o0);
      chk("R7 jms target", 32'(next_pc_o), 32'(15'o10021));
      chk("R7 jms return", 32'(op_wb_o), 32'(12'o0101));
   endtask

   task automatic t_isz();
      apply(3'o0, 3'o0, 15'o31000, 12'o2050, 1'b0, 12'o0, 12'o7777);
      chk("R8 isz wb zero", 32'(op_wb_o), 32'd0);
      chk("R8 isz skip", 32'(skip_o), 32'd1);
      chk("R8 isz skip pc", 32'(next_pc_o), 32'(15'o31002));
      apply(3'o0, 3'o0, 15'o31000, 12'o2050, 1'b0, 12'o0, 12'o0005);
      chk("R8 isz wb", 32'(op_wb_o), 32'(12'o0006));
      chk("R8 isz no skip", 32'(skip_o), 32'd0);
      chk("R8 isz seq pc", 32'(next_pc_o), 32'(15'o31001));
      apply(3'o0, 3'o0, 15'o37777, 12'o2050, 1'b0, 12'o0, 12'o7777);
      chk("R8 isz skip wraps in field", 32'(next_pc_o), 32'(15'o30001));
   endtask

   task automatic t_irq();
      apply(3'o0, 3'o0, 15'o02345, 12'o7402, 1'b1, 12'o1111, 12'o7777);
      chk("R9 irq init addr", 32'(ea_init_o), 32'd0);
      chk("R9 irq final addr", 32'(ea_final_o), 32'd0);
      chk("R9 irq direct", 32'(ind_req_o), 32'd0);
      chk("R9 irq next pc", 32'(next_pc_o), 32'(15'o00001));
      chk("R9 irq saves pc", 32'(op_wb_o), 32'(12'o2345));
      chk("R9 irq wb en", 32'(op_wb_en_o), 32'd1);
      chk("R9 irq no skip", 32'(skip_o), 32'd0);
      chk("R10 clean irq no fault", 32'(irq_fault_o), 32'd0);
   endtask

   task automatic t_fault();
      apply(3'o1, 3'o0, 15'o00010, 12'o0000, 1'b1, 12'o0, 12'o0);
      chk("R10 df fault", 32'(irq_fault_o), 32'd1);
      apply(3'o0, 3'o2, 15'o00010, 12'o0000, 1'b1, 12'o0, 12'o0);
      chk("R10 if fault", 32'(irq_fault_o), 32'd1);
      apply(3'o7, 3'o7, 15'o00010, 12'o0000, 1'b0, 12'o0, 12'o0);
      chk("R10 no irq no fault", 32'(irq_fault_o), 32'd0);
   endtask

   task automatic t_hold();
      apply(3'o0, 3'o4, 15'o40007, 12'o7000, 1'b0, 12'o0, 12'o0);
      chk("R12 valid after accept", 32'(out_valid), 32'd1);
      pc_in = 15'o12345; instr_in = 12'o5000; if_in = 3'o1;
      @(negedge clk);
      chk("R12 valid drops", 32'(out_valid), 32'd0);
      @(negedge clk);
      chk("R12 pc held", 32'(next_pc_o), 32'(15'o40010));
   endtask

   initial begin
      t_reset();
      t_sequential();
      t_page();
      t_indirect();
      t_autoinc();
      t_jmp();
      t_jms();
      t_isz();
      t_irq();
      t_fault();
      t_hold();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule